// File: doc/BRIEF.md
# TDM Slot Selection Controller

This block sits between a time-division-multiplexed serial line and a host register interface. A frame sync pulse starts a frame of `NUM_SLOTS` words, each `WORD_BITS` serial clocks long. At the start of every word slot the block decides whether the transmit side is *enabled* for that slot and whether it is *unmasked*. An enabled slot takes the host's transmit buffer into the shift register. An unmasked slot is the only kind that drives the line. The receive side gathers each incoming word and passes it to the host only for slots selected by the receive mask.

A two-bit transmit mode sets how the enabled set and the unmasked set are derived:

- from nothing, so every slot is both;
- from the transmit mask alone;
- with every slot enabled and only the transmit mask unmasked;
- with the enabled set following the receive mask and the transmit mask narrowing it further.

Ready flags tell the host when to write the next transmit word and when a received word is waiting. A sticky flag records any slot that had to resend a word the host never replaced.

Top module: `tdm_slot_ctrl`

## Requirements
- R1: With `tx_mode` = 2'b00, every slot of the frame is enabled: it copies the buffer and sets `tx_rdy`. Every slot is also unmasked, so `tx_oe` is high for all of them.
- R2: With `tx_mode` = 2'b01, a slot s is enabled and driven only when `tx_mask[s]` is 1. When `tx_mask[s]` is 0 the slot does no copy and `tx_rdy` is untouched apart from host writes. For example, mask 4'b1010 selects slots 1 and 3.
- R3: With `tx_mode` = 2'b10, every slot copies the buffer and sets `tx_rdy`. Only slots with `tx_mask[s]` = 1 raise `tx_oe`.
- R4: With `tx_mode` = 2'b11, slot s is enabled when `rx_mask[s]` is 1. It is driven only when both `rx_mask[s]` and `tx_mask[s]` are 1.
- R5: The `fsync` edge is slot 0, bit 0. The slot index moves on every `WORD_BITS` clocks, up to `NUM_SLOTS` slots, after which the line idles. Transmit data goes out MSB first. Bit i of slot s is presented on `tx_dout` in the cycle after clock edge s*`WORD_BITS`+i, counting the `fsync` edge as edge 0.
- R6: `tx_rdy` is 1 after reset and is set by every buffer-to-shift copy. A `host_wr` clears it. A write in the same cycle as a slot start supplies the word that is copied, and that copy leaves `tx_rdy` set.
- R7: `rx_din` is sampled on the edge after each bit time, MSB first. At the last bit of slot s, if `rx_mask[s]` is 1, the word goes to `host_rdata` and `rx_rdy` is set. `host_rd` clears `rx_rdy`; if a read and a new word arrive on the same edge, the set wins.
- R8: During a masked or disabled slot, and while no frame is running, `tx_oe` is low for the whole word and `tx_dout` is held at 0.
- R9: If an enabled slot starts while `tx_rdy` is still set and no write arrives in that cycle, the slot resends the buffer's old contents. `tx_underrun` is then set and stays set until reset.
- R10: After reset, `tx_rdy` = 1, while `rx_rdy`, `tx_underrun`, `tx_oe` and `host_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | One-cycle frame start pulse |
| tx_mode | input | 2 | Transmit selection mode |
| tx_mask | input | NUM_SLOTS | Transmit selection mask, bit s for slot s |
| rx_mask | input | NUM_SLOTS | Receive enable mask, bit s for slot s |
| host_wr | input | 1 | Host write strobe to the transmit buffer |
| host_wdata | input | WORD_BITS | Host write data |
| host_rd | input | 1 | Host read strobe of the receive word |
| host_rdata | output | WORD_BITS | Last received word of an enabled slot |
| tx_rdy | output | 1 | Transmit buffer may be written |
| rx_rdy | output | 1 | Received word waiting |
| tx_underrun | output | 1 | Sticky stale-word resend flag |
| tx_dout | output | 1 | Serial transmit data (0 when not driven) |
| tx_oe | output | 1 | Transmit pad enable |
| rx_din | input | 1 | Serial receive data |

## Verification
A slot counter that is off by one shows up within one word. `tx_oe` rises in the wrong word and the received word lands under the wrong mask bit. Both are visible on the first frame that has an asymmetric mask such as 4'b1010. A wrong enable or mask decode changes `tx_oe` or the `tx_rdy` edge at the very next slot start. A lost ready or underrun update is exposed within a frame by the per-cycle comparison of `tx_rdy`, `rx_rdy` and `tx_underrun`. A bad shift or capture path corrupts `tx_dout` bit by bit and the `host_rdata` value at the slot end.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

    typedef enum logic [1:0] {
        TXM_ALL        = 2'b00,
        TXM_SEL        = 2'b01,
        TXM_ALL_EN     = 2'b10,
        TXM_FOLLOW_RX  = 2'b11
    } tx_mode_e;

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
    parameter  int WORD_BITS = 8,
    parameter  int NUM_SLOTS = 4,
    localparam int BIT_W  = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    output logic              active,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              slot_start,
    output logic [SLOT_W-1:0] start_slot,
    output logic              slot_end,
    output logic              frame_end
);

    typedef struct packed {
        logic              active;
        logic [BIT_W-1:0]  bits;
        logic [SLOT_W-1:0] slot;
    } tmr_t;

    tmr_t q, d;
    logic last_bit, last_slot;

    assign last_bit   = (q.bits == BIT_W'(WORD_BITS - 1));
    assign last_slot  = (q.slot == SLOT_W'(NUM_SLOTS - 1));
    assign slot_end   = q.active & last_bit;
    assign slot_start = fsync | (slot_end & ~last_slot);
    assign start_slot = fsync ? '0 : q.slot + 1'b1;
    assign frame_end  = slot_end & last_slot & ~fsync;
    assign active     = q.active;
    assign slot_idx   = q.slot;

    always_comb begin
        d = q;
        if (q.active) begin
            d.bits = q.bits + 1'b1;
            if (last_bit) begin
                d.bits = '0;
                if (last_slot) begin
                    d.active = 1'b0;
                end else begin
                    d.slot = q.slot + 1'b1;
                end
            end
        end
        if (fsync) begin
            d.active = 1'b1;
            d.bits   = '0;
            d.slot   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/tdm_slot_select.sv
module tdm_slot_select
    import tdm_slot_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  tx_mode_e             mode,
    input  logic [NUM_SLOTS-1:0] tx_mask,
    input  logic [NUM_SLOTS-1:0] rx_mask,
    output logic [NUM_SLOTS-1:0] en_vec,
    output logic [NUM_SLOTS-1:0] unm_vec
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign en_vec[s]  = (mode == TXM_SEL)       ? tx_mask[s] :
                            (mode == TXM_FOLLOW_RX) ? rx_mask[s] : 1'b1;
        assign unm_vec[s] = (mode == TXM_ALL)       ? 1'b1 :
                            (mode == TXM_FOLLOW_RX) ? (tx_mask[s] & rx_mask[s]) :
                                                      tx_mask[s];
    end

endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path #(
    parameter int WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic                 slot_start,
    input  logic                 frame_end,
    input  logic                 slot_en,
    input  logic                 slot_unm,
    input  logic                 host_wr,
    input  logic [WORD_BITS-1:0] host_wdata,
    output logic                 tx_dout,
    output logic                 tx_oe,
    output logic                 tx_rdy,
    output logic                 tx_underrun
);

    typedef struct packed {
        logic [WORD_BITS-1:0] buf_w;
        logic [WORD_BITS-1:0] shreg;
        logic                 oe;
        logic                 rdy;
        logic                 under;
    } tx_t;

    tx_t q, d;
    logic [WORD_BITS-1:0] load_word;

    assign load_word = host_wr ? host_wdata : q.buf_w;

    always_comb begin
        d = q;
        if (host_wr) begin
            d.buf_w = host_wdata;
            d.rdy   = 1'b0;
        end
        if (active && !slot_start) begin
            d.shreg = {q.shreg[WORD_BITS-2:0], 1'b0};
        end
        if (slot_start) begin
            d.oe = slot_unm;
            if (slot_en) begin
                d.shreg = load_word;
                d.rdy   = 1'b1;
                if (q.rdy && !host_wr) d.under = 1'b1;
            end
        end
        if (frame_end) d.oe = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.rdy <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_dout     = q.oe & q.shreg[WORD_BITS-1];
    assign tx_oe       = q.oe;
    assign tx_rdy      = q.rdy;
    assign tx_underrun = q.under;

endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path #(
    parameter int WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic                 slot_end,
    input  logic                 slot_rx_en,
    input  logic                 rx_din,
    input  logic                 host_rd,
    output logic [WORD_BITS-1:0] rx_word,
    output logic                 rx_rdy
);

    typedef struct packed {
        logic [WORD_BITS-1:0] shreg;
        logic [WORD_BITS-1:0] word;
        logic                 rdy;
    } rx_t;

    rx_t q, d;
    logic [WORD_BITS-1:0] gathered;

    assign gathered = {q.shreg[WORD_BITS-2:0], rx_din};

    always_comb begin
        d = q;
        if (active) d.shreg = gathered;
        if (host_rd) d.rdy = 1'b0;
        if (slot_end && slot_rx_en) begin
            d.word = gathered;
            d.rdy  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_word = q.word;
    assign rx_rdy  = q.rdy;

endmodule

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl
    import tdm_slot_pkg::*;
#(
    parameter int WORD_BITS = 8,
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fsync,
    input  logic [1:0]           tx_mode,
    input  logic [NUM_SLOTS-1:0] tx_mask,
    input  logic [NUM_SLOTS-1:0] rx_mask,
    input  logic                 host_wr,
    input  logic [WORD_BITS-1:0] host_wdata,
    input  logic                 host_rd,
    output logic [WORD_BITS-1:0] host_rdata,
    output logic                 tx_rdy,
    output logic                 rx_rdy,
    output logic                 tx_underrun,
    output logic                 tx_dout,
    output logic                 tx_oe,
    input  logic                 rx_din
);

    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic              frame_active;
    logic [SLOT_W-1:0] slot_idx;
    logic              slot_start;
    logic [SLOT_W-1:0] start_slot;
    logic              slot_end;
    logic              frame_end;
    logic [NUM_SLOTS-1:0] en_vec, unm_vec;

    tdm_slot_timer #(.WORD_BITS(WORD_BITS), .NUM_SLOTS(NUM_SLOTS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .active     (frame_active),
        .slot_idx   (slot_idx),
        .slot_start (slot_start),
        .start_slot (start_slot),
        .slot_end   (slot_end),
        .frame_end  (frame_end)
    );

    tdm_slot_select #(.NUM_SLOTS(NUM_SLOTS)) u_select (
        .mode    (tx_mode_e'(tx_mode)),
        .tx_mask (tx_mask),
        .rx_mask (rx_mask),
        .en_vec  (en_vec),
        .unm_vec (unm_vec)
    );

    tdm_tx_path #(.WORD_BITS(WORD_BITS)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (frame_active),
        .slot_start  (slot_start),
        .frame_end   (frame_end),
        .slot_en     (en_vec[start_slot]),
        .slot_unm    (unm_vec[start_slot]),
        .host_wr     (host_wr),
        .host_wdata  (host_wdata),
        .tx_dout     (tx_dout),
        .tx_oe       (tx_oe),
        .tx_rdy      (tx_rdy),
        .tx_underrun (tx_underrun)
    );

    tdm_rx_path #(.WORD_BITS(WORD_BITS)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (frame_active),
        .slot_end   (slot_end),
        .slot_rx_en (rx_mask[slot_idx]),
        .rx_din     (rx_din),
        .host_rd    (host_rd),
        .rx_word    (host_rdata),
        .rx_rdy     (rx_rdy)
    );

endmodule

// File: rtl/tdm_slot_ctrl_chk.sv
module tdm_slot_ctrl_chk #(
    parameter  int WORD_BITS = 8,
    parameter  int NUM_SLOTS = 4,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           tx_mode,
    input logic [NUM_SLOTS-1:0] tx_mask,
    input logic [NUM_SLOTS-1:0] rx_mask,
    input logic                 host_wr,
    input logic                 host_rd,
    input logic                 tx_rdy,
    input logic                 rx_rdy,
    input logic                 tx_underrun,
    input logic                 tx_dout,
    input logic                 tx_oe,
    input logic                 slot_start,
    input logic [SLOT_W-1:0]    start_slot,
    input logic                 slot_end,
    input logic [SLOT_W-1:0]    slot_idx
);

    AST_MODE00_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && tx_mode == 2'b00) |=> (tx_oe && tx_rdy)); // R1

    AST_MODE01_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && tx_mode == 2'b01 && !tx_mask[start_slot] && !host_wr)
        |=> ($stable(tx_rdy) && !tx_oe)); // R2

    AST_MODE10_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && tx_mode == 2'b10) |=> tx_rdy); // R3

    AST_MODE11_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && tx_mode == 2'b11 && !rx_mask[start_slot] && !host_wr)
        |=> ($stable(tx_rdy) && !tx_oe)); // R4

    AST_OE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> $past(slot_start)); // R8

    AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !tx_dout); // R8

    AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !slot_start) |=> !tx_rdy); // R6

    AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end && rx_mask[slot_idx]) |=> rx_rdy); // R7

    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !slot_end) |=> !rx_rdy); // R7

    AST_UNDER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |=> tx_underrun); // R9

endmodule

bind tdm_slot_ctrl tdm_slot_ctrl_chk #(.WORD_BITS(WORD_BITS), .NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_mode     (tx_mode),
    .tx_mask     (tx_mask),
    .rx_mask     (rx_mask),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .tx_rdy      (tx_rdy),
    .rx_rdy      (rx_rdy),
    .tx_underrun (tx_underrun),
    .tx_dout     (tx_dout),
    .tx_oe       (tx_oe),
    .slot_start  (slot_start),
    .start_slot  (start_slot),
    .slot_end    (slot_end),
    .slot_idx    (slot_idx)
);

// File: tb/tdm_slot_ctrl_test.sv
module tdm_slot_ctrl_test;

    localparam int W  = 8;
    localparam int N  = 4;
    localparam int FR = W * N;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         fsync = 1'b0;
    logic [1:0]   tx_mode = 2'b00;
    logic [N-1:0] tx_mask = '0;
    logic [N-1:0] rx_mask = '0;
    logic         host_wr = 1'b0;
    logic [W-1:0] host_wdata = '0;
    logic         host_rd = 1'b0;
    logic [W-1:0] host_rdata;
    logic         tx_rdy, rx_rdy, tx_underrun, tx_dout, tx_oe;
    logic         rx_din = 1'b0;

    tdm_slot_ctrl #(.WORD_BITS(W), .NUM_SLOTS(N)) uut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .tx_mode(tx_mode),
        .tx_mask(tx_mask), .rx_mask(rx_mask), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .tx_rdy(tx_rdy), .rx_rdy(rx_rdy), .tx_underrun(tx_underrun),
        .tx_dout(tx_dout), .tx_oe(tx_oe), .rx_din(rx_din)
    );

    int nrun = 0;
    int nfail = 0;
    bit done = 0;

    int           kpos = -1;
    int           wcnt = 0;
    int           fidx = 0;
    logic         m_rdy, m_under, m_oe, m_rxrdy, m_dout;
    logic [W-1:0] m_buf, m_cur, m_rdata;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        nrun++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] rxw(input int s, input int f);
        return W'(s * 53 + f * 17 + 150);
    endfunction

    function automatic logic [W-1:0] wval(input int c);
        return W'(c * 29 + 7);
    endfunction

    function automatic logic en_f(input int s);
        case (tx_mode)
            2'b01:   return tx_mask[s];
            2'b11:   return rx_mask[s];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic unm_f(input int s);
        case (tx_mode)
            2'b00:   return 1'b1;
            2'b11:   return tx_mask[s] & rx_mask[s];
            default: return tx_mask[s];
        endcase
    endfunction

    function automatic string mode_tag();
        case (tx_mode)
            2'b00:   return "R1 oe";
            2'b01:   return "R2 oe";
            2'b10:   return "R3 oe";
            default: return "R4 oe";
        endcase
    endfunction

    task automatic model_reset();
        m_rdy = 1'b1; m_under = 1'b0; m_oe = 1'b0; m_rxrdy = 1'b0;
        m_dout = 1'b0; m_buf = '0; m_cur = '0; m_rdata = '0; kpos = -1;
    endtask

    task automatic check_reset();
        chk("R10 tx_rdy", W'(tx_rdy), W'(1));
        chk("R10 rx_rdy", W'(rx_rdy), W'(0));
        chk("R10 underrun", W'(tx_underrun), W'(0));
        chk("R10 tx_oe", W'(tx_oe), W'(0));
        chk("R10 rdata", host_rdata, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fsync = 1'b0; host_wr = 1'b0; host_rd = 1'b0; rx_din = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_reset();
    endtask

    // pol 0: host writes mid-slot when ready; 1: no host activity; 2: writes at slot starts
    task automatic cyc(input logic fs, input int pol);
        int kn, s, i;
        logic wr, rd, st, en;
        logic [W-1:0] wd, ld;
        kn = fs ? 0 : ((kpos >= 0 && kpos < FR) ? kpos + 1 : -1);
        case (pol)
            0:       wr = m_rdy && (kn < 0 || kn % W == 3);
            2:       wr = (kn >= 0 && kn < FR && kn % W == 0);
            default: wr = 1'b0;
        endcase
        rd = (pol != 1) && m_rxrdy && kn >= 0 && (kn % W == 5);
        wd = wval(wcnt);
        fsync = fs; host_wr = wr; host_wdata = wd; host_rd = rd;
        if (kn >= 1 && kn <= FR) begin
            s = (kn - 1) / W; i = (kn - 1) % W;
            rx_din = rxw(s, fidx)[W-1-i];
        end else begin
            rx_din = 1'b0;
        end
        @(posedge clk);
        // model from the requirements
        ld = wr ? wd : m_buf;
        st = (kn >= 0 && kn < FR && kn % W == 0);
        if (st) begin
            s  = kn / W;
            en = en_f(s);
            if (en) begin
                if (m_rdy && !wr) m_under = 1'b1;
                m_cur = ld;
                m_rdy = 1'b1;
            end else if (wr) begin
                m_rdy = 1'b0;
            end
            m_oe = unm_f(s);
        end else if (wr) begin
            m_rdy = 1'b0;
        end
        if (wr) begin m_buf = wd; wcnt++; end
        if (kn == FR) m_oe = 1'b0;
        if (rd) m_rxrdy = 1'b0;
        if (kn >= 1 && kn <= FR && (kn - 1) % W == W - 1) begin
            s = (kn - 1) / W;
            if (rx_mask[s]) begin
                m_rdata = rxw(s, fidx);
                m_rxrdy = 1'b1;
            end
        end
        m_dout = (kn >= 0 && kn < FR) ? (m_oe & m_cur[W-1-(kn % W)]) : 1'b0;
        @(negedge clk);
        chk(m_oe ? mode_tag() : "R8 oe", W'(tx_oe), W'(m_oe));
        chk(m_oe ? "R5 dout" : "R8 dout", W'(tx_dout), W'(m_dout));
        chk("R6 tx_rdy", W'(tx_rdy), W'(m_rdy));
        chk("R9 underrun", W'(tx_underrun), W'(m_under));
        chk("R7 rx_rdy", W'(rx_rdy), W'(m_rxrdy));
        chk("R7 rdata", host_rdata, m_rdata);
        kpos = kn;
    endtask

    task automatic frame(input logic [1:0] md, input logic [N-1:0] tm,
                         input logic [N-1:0] rm, input int pol);
        @(negedge clk);
        tx_mode = md; tx_mask = tm; rx_mask = rm;
        cyc(1'b0, pol);
        cyc(1'b0, pol);
        cyc(1'b1, pol);
        repeat (FR) cyc(1'b0, pol);
        fidx++;
    endtask

    initial begin
        logic [N-1:0] tms [5];
        logic [N-1:0] rms [2];
        tms[0] = 4'b1010; tms[1] = 4'b0101; tms[2] = 4'b1111;
        tms[3] = 4'b0000; tms[4] = 4'b1001;
        rms[0] = 4'b1010; rms[1] = 4'b0011;
        model_reset();
        do_reset();
        // sweep modes and masks with a well-behaved host (R1-R8)
        for (int m = 0; m < 4; m++)
            for (int t = 0; t < 5; t++)
                for (int r = 0; r < 2; r++)
                    frame(2'(m), tms[t], rms[r], 0);
        // write in the same cycle as each slot start (R6)
        frame(2'b00, 4'b1010, 4'b1111, 2);
        frame(2'b10, 4'b0110, 4'b1010, 2);
        frame(2'b11, 4'b1110, 4'b0111, 2);
        // no host service: stale resend and sticky underrun (R9), rx_rdy held (R7)
        frame(2'b01, 4'b1010, 4'b1010, 1);
        chk("R9 sticky after frame", W'(tx_underrun), W'(1));
        frame(2'b00, 4'b1111, 4'b0000, 1);
        // reset clears everything (R10)
        do_reset();
        frame(2'b10, 4'b1010, 4'b1010, 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
            $finish;
        end
    end

endmodule